// File: doc/BRIEF.md
# Reset Supervisor with Activity Watchdog

This block holds a system in reset while the supply is unhealthy and for a fixed settling interval after it recovers. A comparator outside the block reports supply health on a single input; the block keeps reset asserted while that input is low. Once supply health returns, it keeps reset asserted for a further stretch interval before releasing.

The block has two reset pins of opposite polarity. One is active low and one is active high. Each is modelled as an open-drain enable: the block either pulls the pin to its active level or lets it float to an external pull resistor. It never drives a pin to its inactive level. The pins are also sensed as inputs, so a board can force a manual reset. On the active-low pin, a low-to-high transition starts a new full-length reset. On the active-high pin, a high-to-low transition does the same. Edges that the block causes itself, by releasing its own drive, are masked so that they cannot retrigger it.

An activity watchdog watches a single input. Any change on that input, in either direction, restarts the watchdog. If the input stays still for the whole timeout window, the watchdog fires a full-length reset pulse. While reset is asserted, the watchdog is held at zero. The timeout and stretch lengths come from a clock-frequency parameter, and each can be overridden with a short cycle count for test.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, both drive enables are 1. After `rst_n` rises with `supply_good` still low, they stay 1.
- R2: After `supply_good` rises, which is sampled through a two-flop synchronizer, both enables stay 1 through clock edge STRETCH_CYC+1 and read 0 after edge STRETCH_CYC+2. Edges are counted from the first rising edge that sees the new level.
- R3: When `supply_good` falls, the enables become 1 after the third rising edge. They stay 1 for as long as `supply_good` stays low.
- R4: With no activity, the enables become 1 exactly WDOG_CYC edges after a release. After an activity change, they become 1 at edge WDOG_CYC+3 unless activity changes again.
- R5: A rising change and a falling change on `wd_activity` each restart the watchdog window.
- R6: The watchdog does not count while reset is asserted. Activity seen during reset neither shortens nor lengthens the full WDOG_CYC window that follows the release.
- R7: A low-to-high change on `rst_lo_pin_sense` asserts reset after the third rising edge. A low level held on that pin triggers nothing.
- R8: A high-to-low change on `rst_hi_pin_sense` asserts reset after the third rising edge. A high level held on that pin triggers nothing.
- R9: A pin edge caused by the block releasing its own drive never starts a new reset.
- R10: A reset started by a watchdog timeout or a manual pin edge lasts exactly STRETCH_CYC cycles.
- R11: The two drive enables are always equal, so both pins are at their active level together or released together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| supply_good | input | 1 | Supply health from the external comparator; 1 means healthy |
| wd_activity | input | 1 | Watchdog activity input; any change restarts the window |
| rst_lo_pin_sense | input | 1 | Level sensed on the active-low reset pin |
| rst_hi_pin_sense | input | 1 | Level sensed on the active-high reset pin |
| rst_lo_drive_en | output | 1 | 1 pulls the active-low pin to 0; 0 releases it |
| rst_hi_drive_en | output | 1 | 1 pulls the active-high pin to 1; 0 releases it |

## Verification
Every input passes through two synchronizer stages, and edge inputs pass through one more stage for edge detection. The stretch counter then adds one register before the output.

The expected latencies are therefore fixed:
- An assertion caused by a supply drop or a pin edge is due after the third rising edge.
- An activity change is seen on the third edge and restarts the watchdog window from there.
- A release is due STRETCH_CYC edges after the cycle in which the counter was loaded.

All stimulus changes on a falling edge, and every check samples on a later falling edge, counted from the stimulus. Each check therefore lands one half-cycle after the edge where the result is due. For every timing, the bench also checks the cycle just before it, so early and late outputs are both caught.

// File: rtl/supv_pkg.sv
package supv_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_ANY  = 2'd2
   } edge_kind_e;

   // Cycles in (num/den) seconds at hz.
   function automatic longint unsigned scale_cycles(input longint unsigned hz,
                                                    input longint unsigned num,
                                                    input longint unsigned den);
      return (hz * num) / den;
   endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("supv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{INIT}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/supv_edge.sv
module supv_edge #(
   parameter int                   STAGES = 2,
   parameter supv_pkg::edge_kind_e KIND   = supv_pkg::EDGE_ANY,
   parameter logic                 INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic mask,
   output logic pulse
);
   logic level;
   logic prev_q;
   logic raw;

   supv_sync #(.STAGES(STAGES), .INIT(INIT)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (din),
      .dout (level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= INIT;
      else        prev_q <= level;
   end

   if (KIND == supv_pkg::EDGE_RISE) begin : g_rise
      assign raw = level & ~prev_q;
   end else if (KIND == supv_pkg::EDGE_FALL) begin : g_fall
      assign raw = ~level & prev_q;
   end else begin : g_any
      assign raw = level ^ prev_q;
   end

   assign pulse = raw & ~mask;
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
   parameter int unsigned WINDOW = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_clear,
   input  logic kick,
   output logic expire
);
   if (WINDOW < 2) begin : g_bad_window
      $error("supv_wdog: WINDOW must be at least 2");
   end

   localparam int CW = $clog2(WINDOW);
   localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

   logic [CW-1:0] cnt_q;

   assign expire = !hold_clear && !kick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (hold_clear || kick || expire) cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
   parameter int unsigned LENGTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic trig,
   output logic active
);
   if (LENGTH < 2) begin : g_bad_length
      $error("supv_stretch: LENGTH must be at least 2");
   end

   localparam int CW = $clog2(LENGTH + 1);
   localparam logic [CW-1:0] FULL = CW'(LENGTH);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;

   always_comb begin
      if (hold || trig)     cnt_d = FULL;
      else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      else                  cnt_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= FULL;
         active <= 1'b1;
      end else begin
         cnt_q  <= cnt_d;
         active <= (cnt_d != '0);
      end
   end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
   parameter int unsigned CLK_HZ          = 200_000_000,
   parameter int unsigned WDOG_TENTHS_S   = 16,
   parameter int unsigned STRETCH_MS      = 200,
   parameter int unsigned WDOG_CYC_OVR    = 0,
   parameter int unsigned STRETCH_CYC_OVR = 0,
   parameter int          SYNC_STAGES     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_good,
   input  logic wd_activity,
   input  logic rst_lo_pin_sense,
   input  logic rst_hi_pin_sense,
   output logic rst_lo_drive_en,
   output logic rst_hi_drive_en
);
   localparam int unsigned WDOG_CYC = (WDOG_CYC_OVR != 0) ? WDOG_CYC_OVR :
      32'(supv_pkg::scale_cycles(64'(CLK_HZ), 64'(WDOG_TENTHS_S), 64'd10));
   localparam int unsigned STRETCH_CYC = (STRETCH_CYC_OVR != 0) ? STRETCH_CYC_OVR :
      32'(supv_pkg::scale_cycles(64'(CLK_HZ), 64'(STRETCH_MS), 64'd1000));
   // Own-drive mask covers the synchronizer plus the edge register.
   localparam int MASK_LEN = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rst_supervisor: SYNC_STAGES must be at least 2");
   end
   if (STRETCH_CYC < 2 || WDOG_CYC < 2) begin : g_bad_timing
      $error("rst_supervisor: timing counts must be at least 2");
   end

   logic supply_s;
   logic kick;
   logic lo_edge;
   logic hi_edge;
   logic wd_expire;
   logic active;
   logic own_mask;
   logic [MASK_LEN-1:0] drive_hist_q;

   supv_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_supply_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (supply_good),
      .dout (supply_s)
   );

   supv_edge #(.STAGES(SYNC_STAGES), .KIND(supv_pkg::EDGE_ANY), .INIT(1'b0)) u_act_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (wd_activity),
      .mask (1'b0),
      .pulse(kick)
   );

   supv_edge #(.STAGES(SYNC_STAGES), .KIND(supv_pkg::EDGE_RISE), .INIT(1'b1)) u_lo_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rst_lo_pin_sense),
      .mask (own_mask),
      .pulse(lo_edge)
   );

   supv_edge #(.STAGES(SYNC_STAGES), .KIND(supv_pkg::EDGE_FALL), .INIT(1'b0)) u_hi_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rst_hi_pin_sense),
      .mask (own_mask),
      .pulse(hi_edge)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drive_hist_q <= '1;
      else        drive_hist_q <= {drive_hist_q[MASK_LEN-2:0], active};
   end

   assign own_mask = active | (|drive_hist_q);

   supv_wdog #(.WINDOW(WDOG_CYC)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_clear(active),
      .kick      (kick),
      .expire    (wd_expire)
   );

   supv_stretch #(.LENGTH(STRETCH_CYC)) u_stretch (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (!supply_s),
      .trig  (wd_expire | lo_edge | hi_edge),
      .active(active)
   );

   assign rst_lo_drive_en = active;
   assign rst_hi_drive_en = active;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
   parameter int unsigned WDOG_CYC    = 16,
   parameter int unsigned STRETCH_CYC = 8,
   parameter int          SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic supply_good,
   input logic wd_activity,
   input logic drv_lo,
   input logic drv_hi
);
   localparam int unsigned IDLE_MAX = WDOG_CYC + SYNC_STAGES + 1;
   localparam int IW = $clog2(IDLE_MAX + 2);
   localparam int RW = $clog2(STRETCH_CYC + 2);
   localparam logic [IW-1:0] IDLE_LIM = IW'(IDLE_MAX);
   localparam logic [RW-1:0] RUN_SAT  = RW'(STRETCH_CYC);

   logic [IW-1:0] idle_q;
   logic [RW-1:0] run_q;
   logic          act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= '0;
         run_q  <= '0;
         act_q  <= 1'b0;
      end else begin
         act_q <= wd_activity;
         if (drv_lo || (wd_activity != act_q)) idle_q <= '0;
         else if (idle_q <= IDLE_LIM)          idle_q <= idle_q + 1'b1;
         if (!drv_lo)              run_q <= '0;
         else if (run_q < RUN_SAT) run_q <= run_q + 1'b1;
      end
   end

   AST_PINS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      drv_lo == drv_hi); // R11

   AST_SUPPLY_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_good && !$past(supply_good) && !$past(supply_good, 2) && !$past(supply_good, 3))
      |-> drv_lo); // R3

   AST_PULSE_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_lo) |-> (run_q >= RUN_SAT)); // R10

   AST_WDOG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_lo |-> (idle_q <= IDLE_LIM)); // R4
endmodule

bind rst_supervisor rst_supervisor_chk #(
   .WDOG_CYC   (WDOG_CYC),
   .STRETCH_CYC(STRETCH_CYC),
   .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .supply_good(supply_good),
   .wd_activity(wd_activity),
   .drv_lo     (rst_lo_drive_en),
   .drv_hi     (rst_hi_drive_en)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
   localparam int W = 20;
   localparam int S = 12;

   logic clk = 1'b0;
   logic rst_n;
   logic supply_good;
   logic wd_activity;
   logic ext_lo;
   logic ext_hi;
   logic lo_pin;
   logic hi_pin;
   logic drv_lo;
   logic drv_hi;
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   always #2.5 clk = ~clk;

   // Open-drain pin model: either source may pull to the active level.
   assign lo_pin = !(drv_lo | ext_lo);
   assign hi_pin = drv_hi | ext_hi;

   rst_supervisor #(
      .WDOG_CYC_OVR   (W),
      .STRETCH_CYC_OVR(S)
   ) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .supply_good     (supply_good),
      .wd_activity     (wd_activity),
      .rst_lo_pin_sense(lo_pin),
      .rst_hi_pin_sense(hi_pin),
      .rst_lo_drive_en (drv_lo),
      .rst_hi_drive_en (drv_hi)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic exp);
      checks++;
      if (drv_lo !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, drv_lo, exp);
      end
      checks++;
      if (drv_hi !== drv_lo) begin
         errors++;
         $display("FAIL R11 actual=%0b expected=%0b", drv_hi, drv_lo);
      end
   endtask

   // From a release: no activity, released W-1 cycles, asserted on cycle W, then S long.
   task automatic idle_timeout(input string req);
      for (int i = 1; i < W; i++) begin
         tick(1);
         check(req, 1'b0);
      end
      tick(1);
      check("R4", 1'b1);
      tick(S - 1);
      check("R10", 1'b1);
      tick(1);
      check("R10", 1'b0);
   endtask

   initial begin
      rst_n = 1'b0;
      supply_good = 1'b0;
      wd_activity = 1'b0;
      ext_lo = 1'b0;
      ext_hi = 1'b0;
      tick(3);
      check("R1", 1'b1);
      rst_n = 1'b1;
      tick(40);
      check("R1", 1'b1);

      supply_good = 1'b1;
      tick(S + 1);
      check("R2", 1'b1);
      tick(1);
      check("R2", 1'b0);

      idle_timeout("R9");

      // Sweep every safe activity gap; the change alternates in direction.
      for (int g = 1; g <= W - 3; g++) begin
         tick(g);
         wd_activity = ~wd_activity;
         tick(W + 2);
         check("R5", 1'b0);
         tick(1);
         check("R5", 1'b1);
         tick(S - 1);
         check("R10", 1'b1);
         tick(1);
         check("R10", 1'b0);
      end

      // Supply drop, with activity during the hold.
      supply_good = 1'b0;
      tick(2);
      check("R3", 1'b0);
      tick(1);
      check("R3", 1'b1);
      for (int k = 0; k < 5; k++) begin
         tick(4);
         wd_activity = ~wd_activity;
      end
      tick(10);
      check("R3", 1'b1);
      supply_good = 1'b1;
      tick(S + 1);
      check("R2", 1'b1);
      tick(1);
      check("R2", 1'b0);
      idle_timeout("R6");

      // Manual reset on the active-low pin.
      ext_lo = 1'b1;
      tick(6);
      check("R7", 1'b0);
      ext_lo = 1'b0;
      tick(2);
      check("R7", 1'b0);
      tick(1);
      check("R7", 1'b1);
      tick(S - 1);
      check("R10", 1'b1);
      tick(1);
      check("R10", 1'b0);
      idle_timeout("R9");

      // Manual reset on the active-high pin.
      ext_hi = 1'b1;
      tick(6);
      check("R8", 1'b0);
      ext_hi = 1'b0;
      tick(2);
      check("R8", 1'b0);
      tick(1);
      check("R8", 1'b1);
      tick(S - 1);
      check("R10", 1'b1);
      tick(1);
      check("R10", 1'b0);
      idle_timeout("R9");

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule